// File: doc/BRIEF.md
# SD card initialization sequencer

This block walks an SD card from power-up through identification and into the transfer state. It then issues one read. It does not move any bits on the wire itself. It hands a command index and a 32-bit argument to a separate command-frame engine and waits for that engine to report either a short-response payload or a timeout. From each payload the sequencer checks the fields that matter at that step:

- the voltage/pattern echo,
- the OCR ready and capacity bits,
- the relative card address.

It retries the application-specific operating-condition command until the card reports ready, or until a poll budget runs out.

Once the card is selected and switched to the four-bit bus, the sequencer reads from the block address supplied by the host. It issues either a single-block read, or a multi-block read closed by a stop-transmission command. The read address is used as a block number on high-capacity cards. On standard-capacity cards it is converted to a byte address. A pulse on `start` begins a run. The run ends in a ready state or an error state, and both states hold until the next `start`.

Top module: `sd_bringup_seq`

## Requirements
- R1: After reset, `ready`, `error`, `cmdReq` and `highCap` are 0 and `rca` is 0.
- R2: A run starts with CMD0 (argument 0), accepted on either completion kind. It then issues CMD8 with argument 0x000001AA.
- R3: A CMD8 response whose bits 15:0 differ from 0x01AA sets `error`, and no further command is issued.
- R4: A CMD8 timeout marks the card as older-standard. Every ACMD41 then carries argument bit 30 = 0, and `highCap` ends at 0 whatever the OCR says.
- R5: Every ACMD41 (index 41) is directly preceded by CMD55 with argument 0. After a correct CMD8 echo, ACMD41 argument bit 30 is 1.
- R6: The CMD55/ACMD41 pair repeats while ACMD41 response bit 31 is 0. The 1000th response with bit 31 = 0 sets `error`, so at most 1000 ACMD41 commands are sent.
- R7: After the card reports ready, CMD2 and then CMD3 are issued. `rca` takes bits 31:16 of the CMD3 response.
- R8: CMD7 carries {rca, 16'h0}. It is followed by CMD55 with {rca, 16'h0} and by ACMD6 with argument 2.
- R9: With `multiRead` = 0 the read is CMD17. With `multiRead` = 1 it is CMD18 followed by CMD12 with argument 0. `ready` is then set, and `ready` and `error` are never both 1.
- R10: `highCap` is bit 30 of the ready OCR, but only when the CMD8 echo was correct. The read argument is `blockAddr` when `highCap` = 1. Otherwise it is `blockAddr` shifted left by 9 (truncated to 32 bits).
- R11: A timeout on any command other than CMD0 or CMD8 sets `error`, and no further command is issued.
- R12: `cmdReq` is a single-cycle pulse. No new request is made while a response is outstanding.
- R13: `start` is ignored while a run is in progress, including in the cycle where the final response arrives. It is accepted again once `ready` or `error` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a bring-up and read run |
| multiRead | input | 1 | 1 selects multi-block read with stop, 0 selects single-block read; held stable during a run |
| blockAddr | input | 32 | Block number to read; held stable during a run |
| cmdReq | output | 1 | One-cycle request to the command framer |
| cmdIndex | output | 6 | Command index of the request |
| cmdArg | output | 32 | Command argument of the request |
| respValid | input | 1 | Framer pulse: response (or completion) received |
| respTimeout | input | 1 | Framer pulse: no response within its window |
| respData | input | 32 | Payload bits of the short response |
| ready | output | 1 | Run finished successfully |
| error | output | 1 | Run aborted |
| highCap | output | 1 | Card uses block addressing |
| rca | output | 16 | Captured relative card address |

## Verification
The case that needs care is a new `start` arriving in the same cycle that the final command's response completes the read. In that cycle the sequencer would both accept a request and finish a run. The bench provokes it by raising `start` in the exact cycle that the CMD12 response pulse is visible. It then judges the result at the ports: `ready` must rise, and the framer must log no fresh CMD0 afterwards. A second overlap is a poll response arriving just as the poll budget is exhausted. The bench drives exactly 999 and then an unbounded number of busy responses, and compares the ACMD41 count and the final status.

// File: rtl/sd_seq_pkg.sv
package sd_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_GORESET, ST_IFCOND, ST_APP41, ST_OPCOND, ST_CID, ST_RCA,
    ST_SELECT, ST_APP6, ST_WIDTH, ST_READ, ST_STOP, ST_DONE, ST_FAIL
  } seqState_t;

  typedef enum logic [2:0] {
    ARG_ZERO, ARG_IFCOND, ARG_OPCOND, ARG_RCA, ARG_WIDTH, ARG_ADDR
  } argSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic setV2;
    logic capOcr;
    logic capRca;
    logic pollInc;
  } seqStrobe_t;

endpackage

// File: rtl/sd_seq_datapath.sv
module sd_seq_datapath
  import sd_seq_pkg::*;
#(
  parameter int POLL_LIMIT  = 1000,
  parameter int BLOCK_SHIFT = 9,
  parameter logic [3:0]  VOLT_FIELD = 4'h1,
  parameter logic [7:0]  CHECK_BYTE = 8'hAA,
  parameter logic [23:0] OCR_WINDOW = 24'hFF8000
) (
  input  logic        clk,
  input  logic        rstN,
  input  seqStrobe_t  strobe,
  input  argSel_t     argSel,
  input  logic [31:0] blockAddr,
  input  logic [31:16] respHigh,
  input  logic        respCcs,
  output logic [31:0] cmdArg,
  output logic        pollLast,
  output logic        highCap,
  output logic [15:0] rca
);
  localparam int CNT_W = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(POLL_LIMIT - 1);

  logic             isV2;
  logic [CNT_W-1:0] pollCnt;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearAll) begin
      isV2    <= 1'b0;
      highCap <= 1'b0;
      rca     <= '0;
      pollCnt <= '0;
    end else begin
      if (strobe.setV2)   isV2    <= 1'b1;
      if (strobe.capOcr)  highCap <= isV2 & respCcs;
      if (strobe.capRca)  rca     <= respHigh;
      if (strobe.pollInc) pollCnt <= pollCnt + 1'b1;
    end
  end

  assign pollLast = (pollCnt == CNT_LAST);

  always_comb begin
    unique case (argSel)
      ARG_IFCOND: cmdArg = {20'h0, VOLT_FIELD, CHECK_BYTE};
      ARG_OPCOND: cmdArg = {1'b0, isV2, 6'h0, OCR_WINDOW};
      ARG_RCA:    cmdArg = {rca, 16'h0};
      ARG_WIDTH:  cmdArg = 32'd2;
      ARG_ADDR:   cmdArg = highCap ? blockAddr : (blockAddr << BLOCK_SHIFT);
      default:    cmdArg = 32'h0;
    endcase
  end

endmodule

// File: rtl/sd_seq_control.sv
module sd_seq_control
  import sd_seq_pkg::*;
#(
  parameter logic [15:0] ECHO_EXPECT = 16'h01AA
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        multiRead,
  input  logic        respValid,
  input  logic        respTimeout,
  input  logic        respReadyBit,
  input  logic [15:0] respLow,
  input  logic        pollLast,
  output seqStrobe_t  strobe,
  output argSel_t     argSel,
  output logic        cmdReq,
  output logic [5:0]  cmdIndex,
  output logic        ready,
  output logic        error
);
  seqState_t state, nextState;
  logic      waiting, nextWaiting;
  logic      isCmd, respDone;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waiting <= 1'b0;
    end else begin
      state   <= nextState;
      waiting <= nextWaiting;
    end
  end

  assign respDone = waiting & (respValid | respTimeout);

  always_comb begin
    isCmd    = 1'b1;
    argSel   = ARG_ZERO;
    cmdIndex = 6'd0;
    unique case (state)
      ST_GORESET: cmdIndex = 6'd0;
      ST_IFCOND:  begin cmdIndex = 6'd8;  argSel = ARG_IFCOND; end
      ST_APP41:   cmdIndex = 6'd55;
      ST_OPCOND:  begin cmdIndex = 6'd41; argSel = ARG_OPCOND; end
      ST_CID:     cmdIndex = 6'd2;
      ST_RCA:     cmdIndex = 6'd3;
      ST_SELECT:  begin cmdIndex = 6'd7;  argSel = ARG_RCA; end
      ST_APP6:    begin cmdIndex = 6'd55; argSel = ARG_RCA; end
      ST_WIDTH:   begin cmdIndex = 6'd6;  argSel = ARG_WIDTH; end
      ST_READ:    begin cmdIndex = multiRead ? 6'd18 : 6'd17; argSel = ARG_ADDR; end
      ST_STOP:    cmdIndex = 6'd12;
      default:    isCmd = 1'b0;
    endcase
  end

  assign cmdReq = isCmd & ~waiting;
  assign ready  = (state == ST_DONE);
  assign error  = (state == ST_FAIL);

  always_comb begin
    nextState   = state;
    nextWaiting = waiting | cmdReq;
    strobe      = '0;
    if (!isCmd && start) begin
      strobe.clearAll = 1'b1;
      nextState       = ST_GORESET;
    end
    if (respDone) begin
      nextWaiting = 1'b0;
      if (respTimeout && state != ST_GORESET && state != ST_IFCOND) begin
        nextState = ST_FAIL;
      end else begin
        unique case (state)
          ST_GORESET: nextState = ST_IFCOND;
          ST_IFCOND: begin
            if (respTimeout) nextState = ST_APP41;
            else if (respLow == ECHO_EXPECT) begin
              strobe.setV2 = 1'b1;
              nextState    = ST_APP41;
            end else nextState = ST_FAIL;
          end
          ST_APP41: nextState = ST_OPCOND;
          ST_OPCOND: begin
            if (respReadyBit) begin
              strobe.capOcr = 1'b1;
              nextState     = ST_CID;
            end else if (pollLast) nextState = ST_FAIL;
            else begin
              strobe.pollInc = 1'b1;
              nextState      = ST_APP41;
            end
          end
          ST_CID: nextState = ST_RCA;
          ST_RCA: begin
            strobe.capRca = 1'b1;
            nextState     = ST_SELECT;
          end
          ST_SELECT: nextState = ST_APP6;
          ST_APP6:   nextState = ST_WIDTH;
          ST_WIDTH:  nextState = ST_READ;
          ST_READ:   nextState = multiRead ? ST_STOP : ST_DONE;
          ST_STOP:   nextState = ST_DONE;
          default:   nextState = state;
        endcase
      end
    end
  end

endmodule

// File: rtl/sd_bringup_seq.sv
module sd_bringup_seq
  import sd_seq_pkg::*;
#(
  parameter int POLL_LIMIT  = 1000,
  parameter int BLOCK_SHIFT = 9
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        multiRead,
  input  logic [31:0] blockAddr,
  output logic        cmdReq,
  output logic [5:0]  cmdIndex,
  output logic [31:0] cmdArg,
  input  logic        respValid,
  input  logic        respTimeout,
  input  logic [31:0] respData,
  output logic        ready,
  output logic        error,
  output logic        highCap,
  output logic [15:0] rca
);
  localparam logic [3:0] VOLT_FIELD = 4'h1;
  localparam logic [7:0] CHECK_BYTE = 8'hAA;

  seqStrobe_t strobe;
  argSel_t    argSel;
  logic       pollLast;

  sd_seq_control #(
    .ECHO_EXPECT({4'h0, VOLT_FIELD, CHECK_BYTE})
  ) control_i (
    .clk(clk), .rstN(rstN), .start(start), .multiRead(multiRead),
    .respValid(respValid), .respTimeout(respTimeout),
    .respReadyBit(respData[31]), .respLow(respData[15:0]),
    .pollLast(pollLast), .strobe(strobe), .argSel(argSel),
    .cmdReq(cmdReq), .cmdIndex(cmdIndex), .ready(ready), .error(error)
  );

  sd_seq_datapath #(
    .POLL_LIMIT(POLL_LIMIT), .BLOCK_SHIFT(BLOCK_SHIFT),
    .VOLT_FIELD(VOLT_FIELD), .CHECK_BYTE(CHECK_BYTE)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .argSel(argSel),
    .blockAddr(blockAddr), .respHigh(respData[31:16]), .respCcs(respData[30]),
    .cmdArg(cmdArg), .pollLast(pollLast), .highCap(highCap), .rca(rca)
  );

endmodule

// File: rtl/sd_bringup_seq_chk.sv
module sd_bringup_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cmdReq,
  input logic [5:0]  cmdIndex,
  input logic [31:0] cmdArg,
  input logic        respTimeout,
  input logic [31:0] blockAddr,
  input logic        ready,
  input logic        error,
  input logic        highCap,
  input logic [15:0] rca
);
  logic [5:0] lastIdx;

  always_ff @(posedge clk) begin
    if (!rstN) lastIdx <= 6'd63;
    else if (cmdReq) lastIdx <= cmdIndex;
  end

  assert_req_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    cmdReq |=> !cmdReq);

  assert_status_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(ready && error));

  assert_app_prefix_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReq && cmdIndex == 6'd41) |-> (lastIdx == 6'd55));

  assert_select_arg_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReq && cmdIndex == 6'd7) |-> (cmdArg == {rca, 16'h0}));

  assert_width_arg_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReq && cmdIndex == 6'd6) |-> (cmdArg == 32'd2));

  assert_byte_addr_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReq && (cmdIndex == 6'd17 || cmdIndex == 6'd18) && !highCap)
      |-> (cmdArg == {blockAddr[22:0], 9'h0}));

  assert_timeout_abort_R11: assert property (@(posedge clk) disable iff (!rstN)
    (respTimeout && lastIdx != 6'd0 && lastIdx != 6'd8 && lastIdx != 6'd63)
      |=> error);

  assert_fail_silent_R11: assert property (@(posedge clk) disable iff (!rstN)
    error |-> !cmdReq);

endmodule

bind sd_bringup_seq sd_bringup_seq_chk chk_i (
  .clk(clk), .rstN(rstN), .cmdReq(cmdReq), .cmdIndex(cmdIndex),
  .cmdArg(cmdArg), .respTimeout(respTimeout), .blockAddr(blockAddr),
  .ready(ready), .error(error), .highCap(highCap), .rca(rca)
);

// File: tb/sd_bringup_seq_tb.sv
`timescale 1ns/1ps
module sd_bringup_seq_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        multiRead = 1'b0;
  logic [31:0] blockAddr = '0;
  logic        cmdReq;
  logic [5:0]  cmdIndex;
  logic [31:0] cmdArg;
  logic        respValid = 1'b0;
  logic        respTimeout = 1'b0;
  logic [31:0] respData = '0;
  logic        ready, error, highCap;
  logic [15:0] rca;

  always #2.5 clk = ~clk;

  sd_bringup_seq dut_i (
    .clk(clk), .rstN(rstN), .start(start), .multiRead(multiRead),
    .blockAddr(blockAddr), .cmdReq(cmdReq), .cmdIndex(cmdIndex),
    .cmdArg(cmdArg), .respValid(respValid), .respTimeout(respTimeout),
    .respData(respData), .ready(ready), .error(error), .highCap(highCap),
    .rca(rca)
  );

  int total = 0;
  int bad = 0;

  // framer model configuration
  int          cmd8Mode = 0;      // 0 echo, 1 timeout, 2 corrupt echo
  int          busyPolls = 0;
  logic        ccsBit = 1'b0;
  logic [15:0] rcaVal = 16'h0;
  int          timeoutIdx = -1;

  // framer state and log
  logic        pending = 1'b0;
  int          dly = 0;
  logic [5:0]  pendIdx = '0;
  logic [31:0] pendArg = '0;
  int          acmdSeen = 0;
  int          logN = 0;
  int          reqOverlap = 0;
  logic [5:0]  logIdx [64];
  logic [31:0] logArg [64];

  always @(posedge clk) begin
    respValid   <= 1'b0;
    respTimeout <= 1'b0;
    if (cmdReq) begin
      if (pending) reqOverlap <= reqOverlap + 1;
      pending <= 1'b1;
      dly     <= 3;
      pendIdx <= cmdIndex;
      pendArg <= cmdArg;
      if (cmdIndex == 6'd41) acmdSeen <= acmdSeen + 1;
      if (logN < 64) begin
        logIdx[logN] <= cmdIndex;
        logArg[logN] <= cmdArg;
      end
      logN <= logN + 1;
    end else if (pending) begin
      if (cmdReq) reqOverlap <= reqOverlap + 1;
      if (dly > 1) dly <= dly - 1;
      else begin
        pending <= 1'b0;
        if (int'(pendIdx) == timeoutIdx || (pendIdx == 6'd8 && cmd8Mode == 1))
          respTimeout <= 1'b1;
        else begin
          respValid <= 1'b1;
          case (pendIdx)
            6'd8:    respData <= {16'h0, pendArg[15:0] ^ ((cmd8Mode == 2) ? 16'h0001 : 16'h0)};
            6'd41:   respData <= {(acmdSeen > busyPolls), ccsBit, 6'h0, 24'hFF8000};
            6'd3:    respData <= {rcaVal, 16'h0500};
            default: respData <= 32'h0000_0900;
          endcase
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic runSeq(input int limit);
    logN = 0;
    acmdSeen = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 0; i < limit; i++) begin
      if (ready || error) break;
      @(negedge clk);
    end
  endtask

  task automatic checkLog(input string req, input int pos, input int idx);
    check(req, {26'h0, logIdx[pos]}, idx);
  endtask

  task automatic test_reset();
    check("R1 ready", ready, 0);
    check("R1 error", error, 0);
    check("R1 cmdReq", cmdReq, 0);
    check("R1 highCap", highCap, 0);
    check("R1 rca", rca, 0);
  endtask

  task automatic test_v2_single();
    int seq [14] = '{0, 8, 55, 41, 55, 41, 55, 41, 2, 3, 7, 55, 6, 17};
    cmd8Mode = 0; busyPolls = 2; ccsBit = 1'b1; rcaVal = 16'h4D2C;
    timeoutIdx = -1; multiRead = 1'b0; blockAddr = 32'h0000_0123;
    runSeq(5000);
    check("R9 single ready", ready, 1);
    check("R9 single count", logN, 14);
    for (int i = 0; i < 14; i++) checkLog("R7 R9 order", i, seq[i]);
    check("R2 cmd0 arg", logArg[0], 0);
    check("R2 cmd8 arg", logArg[1], 32'h1AA);
    check("R5 cmd55 arg", logArg[2], 0);
    check("R5 hcs bit", logArg[3][30], 1);
    check("R7 rca", rca, 16'h4D2C);
    check("R8 cmd7 arg", logArg[10], 32'h4D2C_0000);
    check("R8 cmd55 arg", logArg[11], 32'h4D2C_0000);
    check("R8 acmd6 arg", logArg[12], 2);
    check("R10 highCap", highCap, 1);
    check("R10 block arg", logArg[13], 32'h123);
  endtask

  task automatic test_v1_multi();
    int seq [11] = '{0, 8, 55, 41, 2, 3, 7, 55, 6, 18, 12};
    cmd8Mode = 1; busyPolls = 0; ccsBit = 1'b1; rcaVal = 16'h0007;
    multiRead = 1'b1; blockAddr = 32'h0000_0005;
    runSeq(5000);
    check("R9 multi ready", ready, 1);
    check("R9 multi count", logN, 11);
    for (int i = 0; i < 11; i++) checkLog("R9 multi order", i, seq[i]);
    check("R4 hcs clear", logArg[3][30], 0);
    check("R4 highCap", highCap, 0);
    check("R10 byte arg", logArg[9], 32'h0000_0A00);
    check("R9 cmd12 arg", logArg[10], 0);
  endtask

  task automatic test_bad_echo();
    cmd8Mode = 2;
    runSeq(5000);
    repeat (20) @(negedge clk);
    check("R3 error", error, 1);
    check("R3 ready", ready, 0);
    check("R3 count", logN, 2);
    cmd8Mode = 0;
  endtask

  task automatic test_poll_limit();
    busyPolls = 999; multiRead = 1'b0;
    runSeq(30000);
    check("R6 ready at 1000th", ready, 1);
    check("R6 acmd count ok", acmdSeen, 1000);
    busyPolls = 5000;
    runSeq(30000);
    repeat (20) @(negedge clk);
    check("R6 abort", error, 1);
    check("R6 acmd count abort", acmdSeen, 1000);
    busyPolls = 0;
  endtask

  task automatic test_timeout();
    int n;
    timeoutIdx = 3;
    runSeq(5000);
    n = logN;
    repeat (20) @(negedge clk);
    check("R11 error", error, 1);
    check("R11 last cmd", logIdx[n-1], 3);
    check("R11 silent", logN, n);
    timeoutIdx = -1;
  endtask

  task automatic test_start_ignored();
    int k;
    multiRead = 1'b1; blockAddr = 32'h10;
    logN = 0; acmdSeen = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (6) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    k = 0;
    while (!(respValid && pendIdx == 6'd12 && !pending) && k < 5000) begin
      @(negedge clk); k++;
    end
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (20) @(negedge clk);
    check("R13 ready", ready, 1);
    check("R13 no restart", logN, 11);
    check("R12 overlap", reqOverlap, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rstN = 1'b1;
    @(negedge clk);
    test_v2_single();
    test_v1_multi();
    test_bad_echo();
    test_poll_limit();
    test_timeout();
    test_start_ignored();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule